// File: doc/BRIEF.md
# Per-CPU Local Interrupt Unit

This block is the interrupt front end of a single processor. It keeps a 32-bit pending word that software can read, set and clear through a small word-addressed register port. It also takes in a per-CPU timer request, a broadcast level-15 request, and a vector of hardware interrupt levels that a system-level controller has already mapped. From these it drives fifteen level-sensitive priority lines, levels 1 to 15, toward the processor core. Bit 0 of the line vector stands for a level that does not exist and is always low.

Software interrupts live in the top fifteen bits of the pending word, bits 31 to 17. Bit n drives priority level n-16. The timer and broadcast requests appear in the pending word at bits 14 and 15. These two bits reach the priority lines only while the global master-disable flag is low. Hardware levels count only when this CPU is the current routing target. In that case they are merged into the lines and into the readable pending bits at their level positions.

The register port has no back-pressure. Every access marked valid is taken in the cycle it is presented. Reads are combinational from the selected word, and writes take effect at the next clock edge. The port addresses 32-bit words: the word index is the byte address divided by four. The priority lines are registered and reflect any write or input change at the same clock edge that captures it.

Top module: `local_irq_unit`

## Requirements
- R1: The register port addresses words, the index being the byte address divided by 4. Word 0 reads the pending word, and words 1, 2 and 3 read as zero.
- R2: A full-word write to word 2 ORs the written bits 31..17 into the pending word. Every other written bit is discarded.
- R3: A full-word write to word 1 clears the pending bits 31..17 and bit 15 wherever the written value has a 1. It never clears bit 14 or any lower bit.
- R4: Pending bit 14 follows the timer input, taking its value at each clock edge.
- R5: Pending bit 15 is set at the edge that sees the broadcast input rise. It is cleared at any edge that sees the input low.
- R6: Pending software bit n (17..31) drives priority line n-16.
- R7: Pending bits 14 and 15 drive priority lines 14 and 15 only while master_dis is low. master_dis does not gate the software or hardware contributions.
- R8: While is_target is high, hw_levels bit k-1 drives priority line k and reads back as pending bit k (k = 1..15). While is_target is low, neither effect happens.
- R9: Priority line 0, pending bit 16, and pending bits 13..0 are always 0, except for bits 13..1 routed from hardware under R8.
- R10: Reset clears the pending word and all priority lines.
- R11: Writes with any byte-enable value other than 4'b1111, and writes to word 0 or word 3, change nothing.
- R12: The priority lines are registered. A write or input change seen at a clock edge appears on the lines just after that edge, and not before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_valid | input | 1 | Register access present this cycle |
| reg_write | input | 1 | 1 = write, 0 = read |
| reg_word | input | 2 | Word index (byte address / 4) |
| reg_be | input | 4 | Byte enables; only 4'b1111 writes |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the selected word |
| timer_in | input | 1 | Per-CPU timer request |
| bcast_in | input | 1 | Broadcast level-15 request |
| hw_levels | input | 15 | Routed hardware levels; bit k-1 is level k |
| is_target | input | 1 | This CPU is the current routing target |
| master_dis | input | 1 | Global master disable |
| irq_lines | output | 16 | Priority lines; bit k is level k, bit 0 always 0 |

## Verification
The bench sweeps each software bit through set and clear and checks that it lands on line n-16. A design with an off-by-one shift would light the neighbouring level. It tries every byte-enable value and every word index with all-ones data. A design that decodes loosely would let bits 13..0 or bit 16 into the pending word, or would accept partial writes. It checks every combination of timer, broadcast and master-disable. It also checks that a clear write leaves bit 14 alone and keeps bit 15 low while the broadcast input stays high. A wrong mask would show up as a stuck or lost level. Finally, it walks each hardware level with the target flag on and off, and samples the lines just before and just after a write edge. This catches outputs that are unregistered or a cycle late.

// File: rtl/lirq_pkg.sv
package lirq_pkg;
  localparam int unsigned TIMER_POS = 14;
  localparam int unsigned BCAST_POS = 15;
  localparam int unsigned SOFT_LO   = 17;
  localparam int unsigned SOFT_SHIFT = 16;

  typedef enum logic [1:0] {
    WORD_PEND = 2'd0,
    WORD_CLR  = 2'd1,
    WORD_SET  = 2'd2,
    WORD_NONE = 2'd3
  } word_e;
endpackage

// File: rtl/lirq_decode.sv
module lirq_decode #(
  parameter int unsigned BE_W = 4
) (
  input  logic            valid,
  input  logic            write,
  input  logic [1:0]      word,
  input  logic [BE_W-1:0] be,
  output logic            do_set,
  output logic            do_clr,
  output logic            rd_pend
);
  import lirq_pkg::*;
  logic full_wr;
  assign full_wr = valid && write && (be == {BE_W{1'b1}});
  assign do_set  = full_wr && (word_e'(word) == WORD_SET);
  assign do_clr  = full_wr && (word_e'(word) == WORD_CLR);
  assign rd_pend = (word_e'(word) == WORD_PEND);
endmodule

// File: rtl/lirq_pending.sv
module lirq_pending #(
  parameter int unsigned DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          do_set,
  input  logic          do_clr,
  input  logic [DW-1:0] wdata,
  input  logic          timer_in,
  input  logic          bcast_in,
  output logic [DW-1:0] pend_q,
  output logic [DW-1:0] pend_d
);
  import lirq_pkg::*;
  localparam logic [DW-1:0] SOFT_MASK = {DW{1'b1}} << SOFT_LO;

  logic          bcast_prev;
  logic [DW-1:0] soft_d;
  logic          b15_d;

  always_comb begin
    soft_d = pend_q & SOFT_MASK;
    if (do_clr) soft_d = soft_d & ~(wdata & SOFT_MASK);
    if (do_set) soft_d = soft_d | (wdata & SOFT_MASK);
    b15_d = bcast_in && (!bcast_prev ||
            (pend_q[BCAST_POS] && !(do_clr && wdata[BCAST_POS])));
    pend_d = soft_d;
    pend_d[BCAST_POS] = b15_d;
    pend_d[TIMER_POS] = timer_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q     <= '0;
      bcast_prev <= 1'b0;
    end else begin
      pend_q     <= pend_d;
      bcast_prev <= bcast_in;
    end
  end

  AST_TIMER_MIRROR: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> pend_q[TIMER_POS] == $past(timer_in)); // R4
  AST_BCAST_LOW_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    !bcast_in |=> !pend_q[BCAST_POS]); // R5
  AST_CLEAR_SOFT: assert property (@(posedge clk) disable iff (!rst_n)
    do_clr |=> ((pend_q & $past(wdata) & SOFT_MASK) == '0)); // R3
endmodule

// File: rtl/lirq_merge.sv
module lirq_merge #(
  parameter int unsigned LEVELS = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LEVELS-1:1] soft_f,
  input  logic              tmr_bit,
  input  logic              b15_bit,
  input  logic [LEVELS-1:1] hw_f,
  input  logic              is_target,
  input  logic              master_dis,
  output logic [LEVELS-1:0] lines_q
);
  import lirq_pkg::*;
  logic [LEVELS-1:0] lines_d;

  assign lines_d[0] = 1'b0;
  for (genvar g = 1; g < LEVELS; g++) begin : g_lane
    logic local_bit;
    if (g == TIMER_POS) begin : g_tmr
      assign local_bit = tmr_bit && !master_dis;
    end else if (g == BCAST_POS) begin : g_b15
      assign local_bit = b15_bit && !master_dis;
    end else begin : g_none
      assign local_bit = 1'b0;
    end
    assign lines_d[g] = soft_f[g] | local_bit | (hw_f[g] & is_target);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lines_q <= '0;
    else        lines_q <= lines_d;
  end

  AST_MDIS_GATES_LOCAL: assert property (@(posedge clk) disable iff (!rst_n)
    (master_dis && !is_target) |=>
      lines_q[LEVELS-1:LEVELS-2] == $past(soft_f[LEVELS-1:LEVELS-2])); // R7
  AST_TARGET_HW: assert property (@(posedge clk) disable iff (!rst_n)
    is_target |=> ((lines_q[LEVELS-1:1] & $past(hw_f)) == $past(hw_f))); // R8
  AST_LINE0_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> !lines_q[0]); // R9
endmodule

// File: rtl/local_irq_unit.sv
module local_irq_unit #(
  parameter int unsigned DW     = 32,
  parameter int unsigned BE_W   = DW / 8,
  parameter int unsigned LEVELS = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_valid,
  input  logic              reg_write,
  input  logic [1:0]        reg_word,
  input  logic [BE_W-1:0]   reg_be,
  input  logic [DW-1:0]     reg_wdata,
  output logic [DW-1:0]     reg_rdata,
  input  logic              timer_in,
  input  logic              bcast_in,
  input  logic [LEVELS-2:0] hw_levels,
  input  logic              is_target,
  input  logic              master_dis,
  output logic [LEVELS-1:0] irq_lines
);
  import lirq_pkg::*;
  localparam int unsigned SOFT_TOP = SOFT_SHIFT + LEVELS - 1;

  logic          do_set, do_clr, rd_pend;
  logic [DW-1:0] pend_q, pend_d, routed;

  lirq_decode #(.BE_W(BE_W)) u_dec (
    .valid(reg_valid), .write(reg_write), .word(reg_word), .be(reg_be),
    .do_set(do_set), .do_clr(do_clr), .rd_pend(rd_pend)
  );

  lirq_pending #(.DW(DW)) u_pend (
    .clk(clk), .rst_n(rst_n), .do_set(do_set), .do_clr(do_clr),
    .wdata(reg_wdata), .timer_in(timer_in), .bcast_in(bcast_in),
    .pend_q(pend_q), .pend_d(pend_d)
  );

  lirq_merge #(.LEVELS(LEVELS)) u_merge (
    .clk(clk), .rst_n(rst_n),
    .soft_f(pend_d[SOFT_TOP:SOFT_SHIFT+1]),
    .tmr_bit(pend_d[TIMER_POS]), .b15_bit(pend_d[BCAST_POS]),
    .hw_f(hw_levels), .is_target(is_target), .master_dis(master_dis),
    .lines_q(irq_lines)
  );

  always_comb begin
    routed = '0;
    if (is_target) routed[LEVELS-1:1] = hw_levels;
    reg_rdata = rd_pend ? (pend_q | routed) : '0;
  end

  AST_LOW_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_pend && !is_target) |-> (reg_rdata[13:0] == '0 && !reg_rdata[16])); // R9
  AST_OTHER_WORDS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_pend |-> reg_rdata == '0); // R1
  AST_PARTIAL_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_valid && reg_write && reg_be != {BE_W{1'b1}})
      |=> (pend_q[DW-1:SOFT_LO] == $past(pend_q[DW-1:SOFT_LO]))); // R11
endmodule

// File: tb/tb_local_irq_unit.sv
module tb_local_irq_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_valid = 1'b0, reg_write = 1'b0;
  logic [1:0]  reg_word = 2'd0;
  logic [3:0]  reg_be = 4'h0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        timer_in = 1'b0, bcast_in = 1'b0;
  logic [14:0] hw_levels = '0;
  logic        is_target = 1'b0, master_dis = 1'b0;
  logic [15:0] irq_lines;

  int tests = 0, fails = 0;
  logic [31:0] m_soft = '0;
  logic        m_b15 = 1'b0, m_tmr = 1'b0, bc_prev = 1'b0;
  localparam logic [31:0] SOFTM = 32'hFFFE_0000;

  local_irq_unit dut (.*);

  always #10 clk = ~clk;

  function automatic logic [15:0] exp_lines();
    logic [15:0] v;
    v = m_soft[31:16];
    if (!master_dis) v = v | {m_b15, m_tmr, 14'b0};
    if (is_target) v = v | {hw_levels, 1'b0};
    v[0] = 1'b0;
    return v;
  endfunction

  function automatic logic [31:0] exp_rd();
    logic [31:0] v;
    v = m_soft | {16'b0, m_b15, m_tmr, 14'b0};
    if (is_target) v = v | {16'b0, hw_levels, 1'b0};
    return v;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chk_all(input string tag);
    chk({tag, " lines"}, {16'b0, irq_lines}, {16'b0, exp_lines()});
    reg_word = 2'd0;
    #1;
    chk({tag, " read"}, reg_rdata, exp_rd());
  endtask

  task automatic wr(input logic [1:0] w, input logic [3:0] be, input logic [31:0] d);
    @(negedge clk);
    reg_valid = 1'b1; reg_write = 1'b1; reg_word = w; reg_be = be; reg_wdata = d;
    @(posedge clk); #1;
    reg_valid = 1'b0; reg_write = 1'b0;
    if (be == 4'hF && w == 2'd2) m_soft = m_soft | (d & SOFTM);
    if (be == 4'hF && w == 2'd1) begin
      m_soft = m_soft & ~(d & SOFTM);
      if (d[15]) m_b15 = 1'b0;
    end
    m_tmr = timer_in;
    if (!bcast_in) m_b15 = 1'b0;
  endtask

  task automatic setin(input logic t, input logic b, input logic md,
                       input logic tg, input logic [14:0] hw);
    @(negedge clk);
    timer_in = t; bcast_in = b; master_dis = md; is_target = tg; hw_levels = hw;
    @(posedge clk); #1;
    m_tmr = t;
    if (b && !bc_prev) m_b15 = 1'b1;
    if (!b) m_b15 = 1'b0;
    bc_prev = b;
  endtask

  initial begin
    #(20 * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    timer_in = 1'b1; bcast_in = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    chk("R10 reset lines", {16'b0, irq_lines}, 32'h0);
    chk("R10 reset read", reg_rdata, 32'h0);
    @(negedge clk); timer_in = 1'b0; bcast_in = 1'b0; rst_n = 1'b1;
    @(posedge clk); #1;
    chk_all("R10 after release");

    for (int n = 17; n < 32; n++) begin
      wr(2'd2, 4'hF, 32'h1 << n);
      chk_all($sformatf("R6 R2 set bit %0d", n));
      wr(2'd1, 4'hF, 32'h1 << n);
      chk_all($sformatf("R3 clear bit %0d", n));
    end

    wr(2'd2, 4'hF, 32'hFFFF_FFFF);
    chk_all("R2 set all ones");
    chk("R9 low bits zero", reg_rdata & 32'h0001_FFFF, 32'h0);
    wr(2'd1, 4'hF, 32'hFFFF_FFFF);
    chk_all("R3 clear all");

    for (int be = 0; be < 15; be++) begin
      wr(2'd2, be[3:0], 32'hFFFF_FFFF);
      chk_all($sformatf("R11 partial be %h", be));
    end
    for (int w = 0; w < 4; w++) begin
      wr(w[1:0], 4'hF, 32'hFFFF_FFFF);
      chk_all($sformatf("R11 word %0d all ones", w));
      wr(2'd1, 4'hF, 32'hFFFF_FFFF);
    end

    wr(2'd2, 4'hF, 32'hA5A6_0000);
    for (int w = 0; w < 4; w++) begin
      reg_word = w[1:0]; #1;
      chk($sformatf("R1 read word %0d", w), reg_rdata, (w == 0) ? exp_rd() : 32'h0);
    end
    wr(2'd1, 4'hF, 32'hFFFF_FFFF);

    for (int md = 0; md < 2; md++)
      for (int t = 0; t < 2; t++)
        for (int b = 0; b < 2; b++) begin
          setin(1'b0, 1'b0, md[0], 1'b0, '0);
          setin(t[0], b[0], md[0], 1'b0, '0);
          chk_all($sformatf("R4 R5 R7 md=%0d t=%0d b=%0d", md, t, b));
        end

    setin(1'b1, 1'b0, 1'b0, 1'b0, '0);
    setin(1'b1, 1'b1, 1'b0, 1'b0, '0);
    chk_all("R5 bcast rise");
    wr(2'd1, 4'hF, 32'hFFFF_FFFF);
    chk_all("R3 clear keeps timer, drops b15");
    setin(1'b1, 1'b1, 1'b0, 1'b0, '0);
    chk_all("R5 b15 stays clear while high");
    setin(1'b0, 1'b0, 1'b0, 1'b0, '0);
    chk_all("R4 timer low");

    for (int tg = 0; tg < 2; tg++)
      for (int g = 1; g < 16; g++) begin
        setin(1'b0, 1'b0, g[0], tg[0], 15'h1 << (g - 1));
        chk_all($sformatf("R8 target=%0d level %0d", tg, g));
      end
    setin(1'b0, 1'b0, 1'b0, 1'b0, '0);

    @(negedge clk);
    reg_valid = 1'b1; reg_write = 1'b1; reg_word = 2'd2; reg_be = 4'hF;
    reg_wdata = 32'h0008_0000;
    #5;
    chk("R12 before edge", {16'b0, irq_lines}, 32'h0);
    @(posedge clk); #1;
    reg_valid = 1'b0; reg_write = 1'b0;
    m_soft = m_soft | 32'h0008_0000;
    chk("R12 after edge", {16'b0, irq_lines}, 32'h0000_0008);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule